// File: doc/BRIEF.md
# Push-Button Debouncer with Typematic Repeat

This block takes the raw level of a mechanical push-button and turns it into clean single-cycle update strobes for a counter or display. The raw level is first passed through a two-stage synchroniser. A press is accepted only after the synchronised level has stayed high for a full debounce window. Contact chatter is assumed to settle well inside 10 ms, and the window defaults to 20 ms. Each accepted press produces exactly one strobe. A debounced level output goes high with that strobe.

If the button is still down once a long initial hold delay has elapsed (0.5 s by default), the block issues another strobe. After that it issues further strobes at a shorter fixed interval (100 ms by default) until the button is let go. Release is filtered by the same debounce window, so chatter when the button is let go never creates an extra strobe.

All delays are given in milliseconds and converted to clock cycles from a clock-frequency parameter. Each converted cycle count is held to at least two cycles.

Top module: `key_autorepeat`

## Requirements
- R1: Suppose `key_raw` goes high before clock edge 0 and stays high for at least DEB cycles, where DEB = CLK_HZ/1000*DEBOUNCE_MS. Then `key_update` is high for exactly the cycle that follows edge DEB+1.
- R2: A high pulse on `key_raw` covering fewer than DEB clock edges produces no `key_update`, and `key_level` stays 0.
- R3: Any low sample during the press window restarts it. Acceptance is then timed as in R1, counting from the last rising of `key_raw`.
- R4: Each `key_update` strobe lasts exactly one clock cycle.
- R5: `key_level` rises in the same cycle as the first strobe of a press. Suppose the press began before edge 0 and `key_raw` went low before edge H. Then `key_level` falls after edge H+DEB+1.
- R6: Any high sample during the release window restarts it. No strobe is issued while releasing, and `key_level` stays 1 until the window completes without interruption.
- R7: Let DLY = CLK_HZ/1000*REPEAT_DELAY_MS. If the key is still held, a second strobe follows edge DEB+1+DLY.
- R8: Let RATE = CLK_HZ/1000*REPEAT_RATE_MS. After the first repeat, a strobe follows every RATE edges while the key is held. For a release before edge H, the last strobe possible is the one after edge H+1; a repeat that falls due at edge H+2 or later is not issued.
- R9: A synchronous active-high `rst` clears `key_level`, `key_update` and all timing. A key still held when reset is released is then timed as a fresh press that began at the release of reset.
- R10: `key_update` is never high while `key_level` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_raw | input | 1 | Asynchronous button level, high when pressed |
| key_level | output | 1 | Debounced button level |
| key_update | output | 1 | One-cycle strobe per accepted press and per repeat |

## Verification
Every result is counted from the first clock edge after a change on `key_raw`. Two synchroniser edges come first. The accept strobe then follows edge DEB+1, the first repeat follows edge DEB+1+DLY, later repeats come every RATE edges, and the level falls after edge H+DEB+1 once the key is released before edge H. The bench drives the input on falling clock edges and compares both outputs on every falling edge against values computed from these formulas. This catches a strobe that arrives one cycle early or late, as well as any extra or missing strobe. The boundary cases are a press lasting exactly DEB cycles, a press lasting one cycle less, and a repeat that falls due just as the release is first seen.

// File: rtl/key_autorepeat.sv
module key_autorepeat #(
  parameter int CLK_HZ          = 50_000_000,
  parameter int DEBOUNCE_MS     = 20,
  parameter int REPEAT_DELAY_MS = 500,
  parameter int REPEAT_RATE_MS  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic key_raw,
  output logic key_level,
  output logic key_update
);

  localparam longint TPM      = longint'(CLK_HZ) / 1000;
  localparam longint DEB_RAW  = TPM * DEBOUNCE_MS;
  localparam longint DLY_RAW  = TPM * REPEAT_DELAY_MS;
  localparam longint RATE_RAW = TPM * REPEAT_RATE_MS;
  localparam int DEB_CYC  = (DEB_RAW  < 2) ? 2 : int'(DEB_RAW);
  localparam int DLY_CYC  = (DLY_RAW  < 2) ? 2 : int'(DLY_RAW);
  localparam int RATE_CYC = (RATE_RAW < 2) ? 2 : int'(RATE_RAW);
  localparam int MAX_A    = (DEB_CYC > DLY_CYC) ? DEB_CYC : DLY_CYC;
  localparam int MAX_CYC  = (MAX_A > RATE_CYC) ? MAX_A : RATE_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMING, ST_HELD, ST_REPEAT, ST_RELEASING
  } state_t;

  logic          sync_a, sync_b;
  state_t        st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= key_raw;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      key_level  <= 1'b0;
      key_update <= 1'b0;
    end else begin
      key_update <= 1'b0;
      case (st)
        ST_IDLE:
          if (sync_b) begin
            st  <= ST_ARMING;
            cnt <= CW'(1);
          end
        ST_ARMING:
          if (!sync_b) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else if (cnt == CW'(DEB_CYC - 1)) begin
            st         <= ST_HELD;
            cnt        <= '0;
            key_level  <= 1'b1;
            key_update <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        ST_HELD:
          if (!sync_b) begin
            st  <= ST_RELEASING;
            cnt <= CW'(1);
          end else if (cnt == CW'(DLY_CYC - 1)) begin
            st         <= ST_REPEAT;
            cnt        <= '0;
            key_update <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        ST_REPEAT:
          if (!sync_b) begin
            st  <= ST_RELEASING;
            cnt <= CW'(1);
          end else if (cnt == CW'(RATE_CYC - 1)) begin
            cnt        <= '0;
            key_update <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        ST_RELEASING:
          if (sync_b) begin
            cnt <= '0;
          end else if (cnt == CW'(DEB_CYC - 1)) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            key_level <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: begin
          st  <= ST_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/key_autorepeat_chk.sv
module key_autorepeat_chk (
  input logic clk,
  input logic rst,
  input logic key_raw,
  input logic key_level,
  input logic key_update
);

  assert_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    key_update |=> !key_update);

  assert_update_needs_level_R10: assert property (@(posedge clk) disable iff (rst)
    key_update |-> key_level);

  assert_level_rise_pulses_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(key_level) |-> key_update);

  assert_rise_needs_press_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(key_level) |-> ($past(key_raw, 3) && $past(key_raw, 4)));

  assert_fall_needs_release_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(key_level) && !$past(rst)) |-> (!$past(key_raw, 3) && !$past(key_raw, 4)));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!key_level && !key_update));

endmodule

bind key_autorepeat key_autorepeat_chk u_chk (
  .clk(clk), .rst(rst), .key_raw(key_raw),
  .key_level(key_level), .key_update(key_update)
);

// File: tb/tb_key_autorepeat.sv
`timescale 1ns/1ps
module tb_key_autorepeat;

  localparam int DEB  = 4;
  localparam int DLY  = 20;
  localparam int RATE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_raw = 1'b0;
  logic key_level, key_update;
  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  key_autorepeat #(
    .CLK_HZ(1000), .DEBOUNCE_MS(DEB), .REPEAT_DELAY_MS(DLY), .REPEAT_RATE_MS(RATE)
  ) dut (
    .clk(clk), .rst(rst), .key_raw(key_raw),
    .key_level(key_level), .key_update(key_update)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_upd(input int i, input int h);
    if (i > h + 2) return 1'b0;
    if (i == DEB + 2) return 1'b1;
    if (i < DEB + 2 + DLY) return 1'b0;
    return ((i - (DEB + 2 + DLY)) % RATE) == 0;
  endfunction

  function automatic bit exp_lvl(input int i, input int h);
    return (h >= DEB) && (i >= DEB + 2) && (i < h + DEB + 2);
  endfunction

  task automatic sample(input int i, input int h, input string req);
    chk(key_update == exp_upd(i, h), req, $sformatf("update at cycle %0d", i),
        int'(key_update), int'(exp_upd(i, h)));
    chk(key_level == exp_lvl(i, h), req, $sformatf("level at cycle %0d", i),
        int'(key_level), int'(exp_lvl(i, h)));
  endtask

  task automatic run_press(input int h, input string req);
    key_raw = 1'b1;
    for (int i = 1; i <= h + DEB + 6; i++) begin
      @(negedge clk);
      sample(i, h, req);
      if (i == h) key_raw = 1'b0;
    end
  endtask

  task automatic test_reset_state;
    chk(key_level == 1'b0, "R9", "level in reset", int'(key_level), 0);
    chk(key_update == 1'b0, "R9", "update in reset", int'(key_update), 0);
  endtask

  task automatic test_boundary_tap;
    run_press(DEB, "R1 R5");
  endtask

  task automatic test_short_glitch;
    run_press(DEB - 1, "R2");
  endtask

  task automatic test_press_bounce;
    key_raw = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk(key_update == 1'b0, "R3", "update during bounce", int'(key_update), 0);
      chk(key_level == 1'b0, "R3", "level during bounce", int'(key_level), 0);
      if (i == 2 || i == 5) key_raw = 1'b0;
      if (i == 3) key_raw = 1'b1;
    end
    run_press(20, "R3");
  endtask

  task automatic test_release_chatter;
    key_raw = 1'b1;
    for (int i = 1; i <= 16 + DEB + 6; i++) begin
      @(negedge clk);
      sample(i, 16, "R6");
      if (i == 12 || i == 16) key_raw = 1'b0;
      if (i == 14) key_raw = 1'b1;
    end
  endtask

  task automatic test_long_hold;
    run_press(60, "R4 R7 R8");
  endtask

  task automatic test_repeat_at_release;
    run_press(59, "R8");
  endtask

  task automatic test_reset_mid_hold;
    key_raw = 1'b1;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(key_level == 1'b0, "R9", "level after reset mid hold", int'(key_level), 0);
    chk(key_update == 1'b0, "R9", "update after reset mid hold", int'(key_update), 0);
    rst = 1'b0;
    run_press(10, "R9 R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_state();
    rst = 1'b0;
    @(negedge clk);
    test_boundary_tap();
    test_short_glitch();
    test_press_bounce();
    test_release_chatter();
    test_long_hold();
    test_repeat_at_release();
    test_reset_mid_hold();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule